// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects the interrupt sources that belong to each core of a four-core cluster and turns them into one IRQ line and one FIQ line per core. There are four timer levels and four mailbox levels per core, plus one GPU line and one performance-monitor line that the cores share. Each per-core source has its own IRQ enable and FIQ enable. When the FIQ enable is set, the source is delivered as FIQ only. The shared GPU line goes to the core named in a routing register. The shared monitor line goes to every core whose bit is set in a mask, and that mask is changed by write-one-to-set and write-one-to-clear locations.

Software reaches the block through a single-cycle register bus with strobe, direction, byte address, write data and registered read data. For each core it can read an IRQ pending word and a FIQ pending word. These words are level views of the live inputs gated by the current configuration, so a pending bit drops as soon as its source drops. The mailbox storage and the timers themselves sit outside the block and supply only their levels.

Top module: `core_irq_router`

## Requirements
- R1: After reset every enable and the monitor mask are zero, both GPU routing fields select core 0, bus_rdata is zero, and no irq_out or fiq_out bit is high while the GPU line is low.
- R2: The word at 0x40+4*c is core c's timer control. Bits [3:0] are IRQ enables and bits [7:4] are FIQ enables for timer inputs timer_lvl[4*c+k], which appear as pending bits k (0..3). The word reads back its 8 stored bits with zero above them.
- R3: The word at 0x50+4*c is core c's mailbox control, with the same layout for mailbox_lvl[4*c+k]. Those sources appear as pending bits 4+k.
- R4: A timer or mailbox source whose FIQ enable is set appears in the FIQ pending word and never in the IRQ pending word, whatever its IRQ enable holds.
- R5: Bits [1:0] at 0x0C name the core whose IRQ pending bit 8 follows gpu_lvl. Bits [3:2] name the core whose FIQ pending bit 8 follows it. Bit 8 of the other cores stays 0.
- R6: Writing ones to 0x10 sets those bits of the 4-bit monitor mask, and writing ones to 0x14 clears them. Zero bits leave the mask as it is, and both addresses read the mask in bits [3:0]. IRQ pending bit 9 of core c is pmu_lvl AND mask[c]. FIQ pending bit 9 is always 0.
- R7: The IRQ pending word of core c reads at 0x60+4*c and the FIQ pending word at 0x70+4*c. Both are read-only, and writes to them change nothing.
- R8: irq_out[c] and fiq_out[c] are the OR of core c's IRQ and FIQ pending words. They follow input levels in the same cycle, with no register in the path.
- R9: A read strobe loads bus_rdata at the clock edge that samples it. bus_rdata then holds until the next read strobe. A configuration write takes effect from the cycle after its strobe.
- R10: Addresses outside the map, including any address with bits [1:0] not zero, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| timer_lvl | input | 16 | Timer levels, four per core, core c at [4c+3:4c] |
| mailbox_lvl | input | 16 | Mailbox levels, four per core, core c at [4c+3:4c] |
| gpu_lvl | input | 1 | Shared GPU interrupt level |
| pmu_lvl | input | 1 | Shared performance-monitor level |
| irq_out | output | 4 | IRQ line per core |
| fiq_out | output | 4 | FIQ line per core |

## Verification
Read results are due one cycle after the read strobe. The driver queues the expected word at the moment it raises the strobe, and the monitor pops and compares it at the falling edge that follows the sampling edge. Interrupt outputs are combinational. They are compared a nanosecond after the falling edge on which inputs change, and configuration writes are judged one cycle after their strobe. Every expected value comes from a register model kept by the bench from the requirements, not from the design.

// File: rtl/core_irq_router.sv
module core_irq_router #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [15:0]       timer_lvl,
  input  logic [15:0]       mailbox_lvl,
  input  logic              gpu_lvl,
  input  logic              pmu_lvl,
  output logic [3:0]        irq_out,
  output logic [3:0]        fiq_out
);
  localparam int NC = 4;
  localparam int PW = 10;
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_PSET  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_PCLR  = ADDR_W'(8'h14);

  logic [3:0]             gpu_route;
  logic [NC-1:0]          pmu_en;
  logic [NC-1:0][7:0]     tmr_ctl;
  logic [NC-1:0][7:0]     mbx_ctl;
  logic [NC-1:0][PW-1:0]  irq_pend;
  logic [NC-1:0][PW-1:0]  fiq_pend;
  logic [DATA_W-1:0]      rd_mux;

  wire wr_stb = bus_valid & bus_write;
  wire rd_stb = bus_valid & ~bus_write;
  wire unused_wdata = ^bus_wdata[DATA_W-1:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpu_route <= '0;
      pmu_en    <= '0;
      tmr_ctl   <= '0;
      mbx_ctl   <= '0;
    end else if (wr_stb) begin
      if (bus_addr == A_ROUTE) gpu_route <= bus_wdata[3:0];
      if (bus_addr == A_PSET)  pmu_en <= pmu_en | bus_wdata[NC-1:0];
      if (bus_addr == A_PCLR)  pmu_en <= pmu_en & ~bus_wdata[NC-1:0];
      for (int c = 0; c < NC; c++) begin
        if (bus_addr == ADDR_W'(8'h40 + 4 * c)) tmr_ctl[c] <= bus_wdata[7:0];
        if (bus_addr == ADDR_W'(8'h50 + 4 * c)) mbx_ctl[c] <= bus_wdata[7:0];
      end
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_core
    wire [3:0] tl = timer_lvl[4*c +: 4];
    wire [3:0] ml = mailbox_lvl[4*c +: 4];
    wire [3:0] t_fiq = tmr_ctl[c][7:4];
    wire [3:0] m_fiq = mbx_ctl[c][7:4];

    assign irq_pend[c] = {pmu_lvl & pmu_en[c],
                          gpu_lvl & (gpu_route[1:0] == 2'(c)),
                          ml & mbx_ctl[c][3:0] & ~m_fiq,
                          tl & tmr_ctl[c][3:0] & ~t_fiq};
    assign fiq_pend[c] = {1'b0,
                          gpu_lvl & (gpu_route[3:2] == 2'(c)),
                          ml & m_fiq,
                          tl & t_fiq};
    assign irq_out[c] = |irq_pend[c];
    assign fiq_out[c] = |fiq_pend[c];
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_ROUTE) rd_mux = DATA_W'(gpu_route);
    if (bus_addr == A_PSET || bus_addr == A_PCLR) rd_mux = DATA_W'(pmu_en);
    for (int c = 0; c < NC; c++) begin
      if (bus_addr == ADDR_W'(8'h40 + 4 * c)) rd_mux = DATA_W'(tmr_ctl[c]);
      if (bus_addr == ADDR_W'(8'h50 + 4 * c)) rd_mux = DATA_W'(mbx_ctl[c]);
      if (bus_addr == ADDR_W'(8'h60 + 4 * c)) rd_mux = DATA_W'(irq_pend[c]);
      if (bus_addr == ADDR_W'(8'h70 + 4 * c)) rd_mux = DATA_W'(fiq_pend[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_stb) bus_rdata <= rd_mux;
  end
endmodule

module core_irq_router_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [3:0]           wlow,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [3:0]           gpu_route,
  input logic [3:0]           pmu_en,
  input logic [3:0][7:0]      tmr_ctl,
  input logic [3:0][7:0]      mbx_ctl,
  input logic [3:0][9:0]      irq_pend,
  input logic [3:0][9:0]      fiq_pend
);
  logic cfg_hit;
  always_comb begin
    cfg_hit = (bus_addr == ADDR_W'(8'h0C)) || (bus_addr == ADDR_W'(8'h10)) ||
              (bus_addr == ADDR_W'(8'h14));
    for (int c = 0; c < 4; c++)
      if (bus_addr == ADDR_W'(8'h40 + 4 * c) || bus_addr == ADDR_W'(8'h50 + 4 * c))
        cfg_hit = 1'b1;
  end

  wire [3:0] gpu_irq_bits = {irq_pend[3][8], irq_pend[2][8], irq_pend[1][8], irq_pend[0][8]};
  wire [3:0] gpu_fiq_bits = {fiq_pend[3][8], fiq_pend[2][8], fiq_pend[1][8], fiq_pend[0][8]};

  for (genvar c = 0; c < 4; c++) begin : g_chk
    assert_fiq_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend[c][7:0] & fiq_pend[c][7:0]) == 8'h00);
    assert_pmu_fiq_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_pend[c][9] == 1'b0);
    assert_pmu_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend[c][9] |-> pmu_en[c]);
  end

  assert_gpu_irq_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_irq_bits));
  assert_gpu_fiq_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpu_fiq_bits));
  assert_pmu_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(8'h10)) |=>
      pmu_en == ($past(pmu_en) | $past(wlow)));
  assert_pmu_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(8'h14)) |=>
      pmu_en == ($past(pmu_en) & ~$past(wlow)));
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));
  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !cfg_hit) |=>
      ($stable(gpu_route) && $stable(pmu_en) && $stable(tmr_ctl) && $stable(mbx_ctl)));
endmodule

bind core_irq_router core_irq_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .wlow(bus_wdata[3:0]), .bus_rdata(bus_rdata),
  .gpu_route(gpu_route), .pmu_en(pmu_en), .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl),
  .irq_pend(irq_pend), .fiq_pend(fiq_pend)
);

// File: tb/core_irq_router_tb_top.sv
module core_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] timer_lvl = '0;
  logic [15:0] mailbox_lvl = '0;
  logic        gpu_lvl = 1'b0;
  logic        pmu_lvl = 1'b0;
  logic [3:0]  irq_out;
  logic [3:0]  fiq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  logic [3:0]  m_route = '0;
  logic [3:0]  m_pmu = '0;
  logic [7:0]  m_tmr[4] = '{default: 8'h00};
  logic [7:0]  m_mbx[4] = '{default: 8'h00};

  always #2 clk = ~clk;

  core_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_lvl(timer_lvl), .mailbox_lvl(mailbox_lvl), .gpu_lvl(gpu_lvl),
    .pmu_lvl(pmu_lvl), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  function automatic logic [9:0] model_pend(int c, bit fiq);
    logic [3:0] tl = timer_lvl[4*c +: 4];
    logic [3:0] ml = mailbox_lvl[4*c +: 4];
    logic [3:0] tf = m_tmr[c][7:4];
    logic [3:0] mf = m_mbx[c][7:4];
    if (fiq)
      return {1'b0, gpu_lvl && (int'(m_route[3:2]) == c), ml & mf, tl & tf};
    return {pmu_lvl & m_pmu[c], gpu_lvl && (int'(m_route[1:0]) == c),
            ml & m_mbx[c][3:0] & ~mf, tl & m_tmr[c][3:0] & ~tf};
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    if (a == 8'h0C) return {28'h0, m_route};
    if (a == 8'h10 || a == 8'h14) return {28'h0, m_pmu};
    for (int c = 0; c < 4; c++) begin
      if (a == 8'(8'h40 + 4 * c)) return {24'h0, m_tmr[c]};
      if (a == 8'(8'h50 + 4 * c)) return {24'h0, m_mbx[c]};
      if (a == 8'(8'h60 + 4 * c)) return {22'h0, model_pend(c, 1'b0)};
      if (a == 8'(8'h70 + 4 * c)) return {22'h0, model_pend(c, 1'b1)};
    end
    return 32'h0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (a == 8'h0C) m_route = d[3:0];
    if (a == 8'h10) m_pmu = m_pmu | d[3:0];
    if (a == 8'h14) m_pmu = m_pmu & ~d[3:0];
    for (int c = 0; c < 4; c++) begin
      if (a == 8'(8'h40 + 4 * c)) m_tmr[c] = d[7:0];
      if (a == 8'(8'h50 + 4 * c)) m_mbx[c] = d[7:0];
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic check_lines(input string tag);
    logic [3:0] ei, ef;
    #1;
    for (int c = 0; c < 4; c++) begin
      ei[c] = |model_pend(c, 1'b0);
      ef[c] = |model_pend(c, 1'b1);
    end
    check({28'h0, irq_out}, {28'h0, ei}, {tag, " irq_out"});
    check({28'h0, fiq_out}, {28'h0, ef}, {tag, " fiq_out"});
  endtask

  always @(posedge clk) rd_seen <= rst_n && bus_valid && !bus_write;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: read data with no expected entry, actual %h expected none", bus_rdata);
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(bus_rdata, 32'h0, "R1 rdata after reset");
    check_lines("R1 reset");
    bus_rd(8'h0C, "R1 routing reset");
    bus_rd(8'h10, "R1 monitor mask reset");
    bus_rd(8'h4C, "R1 timer ctl reset");
    @(negedge clk);
    timer_lvl = 16'hFFFF; mailbox_lvl = 16'hFFFF;
    check_lines("R1 all enables zero");

    // R2 timer IRQ enables, upper write bits dropped
    bus_wr(8'h44, 32'hFFFF_FF05);
    check_lines("R2 timer irq core1");
    bus_rd(8'h44, "R2 timer ctl readback");
    bus_rd(8'h64, "R2 core1 irq pending");

    // R4 FIQ overrides IRQ
    bus_wr(8'h48, 32'h11);
    bus_rd(8'h68, "R4 core2 irq pending empty");
    bus_rd(8'h78, "R4 core2 fiq pending");
    check_lines("R4 lines");
    check({31'h0, irq_out[2]}, 32'h0, "R4 core2 irq_out low");

    // R3 mailbox enables
    bus_wr(8'h5C, 32'h0A);
    bus_wr(8'h50, 32'h30);
    bus_rd(8'h6C, "R3 core3 irq pending");
    bus_rd(8'h70, "R3 core0 fiq pending");
    bus_rd(8'h5C, "R3 mbox ctl readback");

    // R8 level following in the same cycle
    @(negedge clk);
    mailbox_lvl[13] = 1'b0; mailbox_lvl[15] = 1'b0;
    check_lines("R8 mailbox drop");
    bus_rd(8'h6C, "R8 core3 irq pending after drop");
    @(negedge clk);
    timer_lvl = 16'h0000;
    check_lines("R8 timers low");

    // R5 GPU routing
    @(negedge clk);
    gpu_lvl = 1'b1;
    check_lines("R5 gpu default core0");
    bus_rd(8'h60, "R5 core0 irq pending gpu");
    bus_rd(8'h70, "R5 core0 fiq pending gpu");
    bus_wr(8'h0C, 32'h0000_000E);
    check_lines("R5 gpu rerouted");
    bus_rd(8'h68, "R5 core2 irq pending gpu");
    bus_rd(8'h7C, "R5 core3 fiq pending gpu");
    bus_rd(8'h60, "R5 core0 irq no gpu");

    // R6 monitor mask set/clear
    @(negedge clk);
    pmu_lvl = 1'b1;
    bus_wr(8'h10, 32'h9);
    bus_rd(8'h14, "R6 mask after set");
    bus_rd(8'h60, "R6 core0 irq pmu bit");
    bus_rd(8'h7C, "R6 core3 fiq no pmu bit");
    bus_wr(8'h14, 32'h1);
    bus_rd(8'h10, "R6 mask after clear");
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h10, "R6 zero write keeps mask");
    check_lines("R6 lines");

    // R7 pending words read-only
    bus_wr(8'h60, 32'h3FF);
    bus_wr(8'h74, 32'h3FF);
    bus_rd(8'h60, "R7 core0 irq pending unchanged");
    bus_rd(8'h74, "R7 core1 fiq pending unchanged");
    check_lines("R7 lines");

    // R10 unmapped and misaligned
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_wr(8'h41, 32'hFF);
    bus_wr(8'h0D, 32'h0);
    bus_rd(8'h20, "R10 unmapped read");
    bus_rd(8'h41, "R10 misaligned read");
    bus_rd(8'h40, "R10 timer ctl unchanged");
    bus_rd(8'h0C, "R10 routing unchanged");
    check_lines("R10 lines");

    // R9 read data holds, writes effective next cycle
    bus_rd(8'h0C, "R9 routing read");
    @(negedge clk);
    held = bus_rdata;
    bus_wr(8'h0C, 32'h0);
    check(bus_rdata, held, "R9 rdata holds across write");
    check_lines("R9 write effective next cycle");
    @(negedge clk);
    bus_addr = 8'h14;
    @(negedge clk);
    check(bus_rdata, held, "R9 rdata holds without strobe");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9: pending reads actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule